// File: doc/BRIEF.md
# Picture-in-picture window overlay controller

This block places a small inset picture on a main video raster. It corrects the polarity of the horizontal and vertical reference pulses and finds their leading edges. It counts pixels from each line start and lines from each field start, and compares the counts with a window rectangle. The rectangle's corner is set on a coarse 64-by-64 grid, and its size is one quarter or one third of the main raster in each axis.

Each cycle the block reports whether the current pixel lies inside the inset, or inside the two-pixel, two-line frame drawn around it. On frame pixels it outputs the programmed frame colour. Inside the inset it gives a linear read address into the stored small picture. It also gates the capture-side write strobe, so that a frozen field stays in memory.

A plain register write port stands in for the serial control bus. Polarity bits act at once. Every other setting is held in a shadow copy and applied at the next field start, so a window never changes shape partway down the screen.

Top module: `pip_window_ctrl`

## Requirements
- R1: An active-low reset clears every control register to zero and sets both counters to their saturated maximum. After reset `win_active` and `border_active` are 0, `rd_addr` and `border_color` are 0, and `cap_we` follows `cap_valid`.
- R2: Register write decoding, selected by `reg_addr`:
  - 0: horizontal step, `reg_wdata[5:0]`.
  - 1: vertical step, `reg_wdata[5:0]`.
  - 2: frame colour, `reg_wdata[7:0]`.
  - 3: control. Bit 0 selects the size (0 = quarter, 1 = third). Bit 1 is freeze. Bit 2 makes the horizontal reference active-low. Bit 3 makes the vertical reference active-low.
  The window's first pixel is step_h*HSTEP and its first line is step_v*VSTEP.
- R3: The window is MAIN_W/4 by MAIN_H/4 when the size bit is 0, and MAIN_W/3 by MAIN_H/3 when it is 1.
- R4: Inside the window, `rd_addr` = (line - first line) * width + (pixel - first pixel), so it rises by one per pixel along a row. Outside the window it is 0.
- R5: `border_active` is 1 inside the frame that extends two pixels and two lines beyond the window on every side, and is never 1 together with `win_active`. `border_color` carries the frame colour while `border_active` is 1 and is 0 otherwise.
- R6: A corrected vertical edge sets the line count to 0, and it wins over a horizontal edge in the same cycle. A corrected horizontal edge alone advances the line count. Any horizontal edge restarts the pixel count, so pixel k is k clocks after the edge clock.
- R7: With a polarity bit set, the falling edge of that raw input is the active edge. With the bit clear, the rising edge is the active edge. The other edge has no effect.
- R8: `cap_we` equals `cap_valid` while the applied freeze bit is 0, and is 0 while it is 1.
- R9: Step, size, colour and freeze writes take effect only at the next field start. A write in the same cycle as a field start takes effect at the field start after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hsync_in | input | 1 | Raw horizontal reference pulse |
| vsync_in | input | 1 | Raw vertical reference pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| cap_valid | input | 1 | Capture side has a pixel to store |
| win_active | output | 1 | Current pixel is inside the inset |
| border_active | output | 1 | Current pixel is on the inset frame |
| border_color | output | 8 | Frame colour on frame pixels, else 0 |
| rd_addr | output | AW | Read address of the stored inset pixel |
| cap_we | output | 1 | Capture write enable after freeze gating |

## Verification
Two events can arrive in the same clock: a field start, which loads the applied settings, and a register write, which updates the shadow copy. The bench issues a position write in the exact cycle of a vertical edge. It then checks that the rest of that field still draws the window at the old position, and that the next field moves it. A second coincidence is covered by every probe: each field starts with horizontal and vertical edges together, and the line count is judged to begin at 0 rather than 1.

// File: rtl/pip_window_ctrl.sv
module pip_window_ctrl #(
  parameter int MAIN_W = 96,
  parameter int MAIN_H = 72,
  parameter int HSTEP  = 1,
  parameter int VSTEP  = 1,
  parameter int PX_W   = 8,
  parameter int LN_W   = 8,
  parameter int BORDER = 2,
  localparam int AW = $clog2((MAIN_W / 3) * (MAIN_H / 3))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          cap_valid,
  output logic          win_active,
  output logic          border_active,
  output logic [7:0]    border_color,
  output logic [AW-1:0] rd_addr,
  output logic          cap_we
);
  localparam logic [15:0] QW = 16'(MAIN_W / 4);
  localparam logic [15:0] QH = 16'(MAIN_H / 4);
  localparam logic [15:0] TW = 16'(MAIN_W / 3);
  localparam logic [15:0] TH = 16'(MAIN_H / 3);
  localparam logic [15:0] BW = 16'(BORDER);
  localparam logic [PX_W-1:0] PX_MAX = '1;
  localparam logic [LN_W-1:0] LN_MAX = '1;

  logic [5:0] hstep_s, vstep_s, hstep_a, vstep_a;
  logic [7:0] col_s, col_a;
  logic       size_s, size_a, frz_s, frz_a;
  logic       hpol, vpol;
  logic       h_q, v_q;
  logic [PX_W-1:0] px;
  logic [LN_W-1:0] ln;

  wire h_cor  = hsync_in ^ hpol;
  wire v_cor  = vsync_in ^ vpol;
  wire h_edge = h_cor & ~h_q;
  wire v_edge = v_cor & ~v_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hstep_s <= '0; vstep_s <= '0; col_s <= '0;
      size_s <= 1'b0; frz_s <= 1'b0; hpol <= 1'b0; vpol <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: hstep_s <= reg_wdata[5:0];
        2'd1: vstep_s <= reg_wdata[5:0];
        2'd2: col_s   <= reg_wdata;
        default: begin
          size_s <= reg_wdata[0];
          frz_s  <= reg_wdata[1];
          hpol   <= reg_wdata[2];
          vpol   <= reg_wdata[3];
        end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hstep_a <= '0; vstep_a <= '0; col_a <= '0; size_a <= 1'b0; frz_a <= 1'b0;
    end else if (v_edge) begin
      hstep_a <= hstep_s; vstep_a <= vstep_s; col_a <= col_s;
      size_a <= size_s; frz_a <= frz_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_q <= 1'b0; v_q <= 1'b0; px <= PX_MAX; ln <= LN_MAX;
    end else begin
      h_q <= h_cor;
      v_q <= v_cor;
      if (h_edge) px <= '0;
      else if (px != PX_MAX) px <= px + 1'b1;
      if (v_edge) ln <= '0;
      else if (h_edge && ln != LN_MAX) ln <= ln + 1'b1;
    end

  wire [15:0] x0  = 16'(hstep_a) * 16'(HSTEP);
  wire [15:0] y0  = 16'(vstep_a) * 16'(VSTEP);
  wire [15:0] ww  = size_a ? TW : QW;
  wire [15:0] wh  = size_a ? TH : QH;
  wire [15:0] pxw = 16'(px);
  wire [15:0] lnw = 16'(ln);

  wire in_x = (pxw >= x0) && (pxw < x0 + ww);
  wire in_y = (lnw >= y0) && (lnw < y0 + wh);
  wire fr_x = (pxw + BW >= x0) && (pxw < x0 + ww + BW);
  wire fr_y = (lnw + BW >= y0) && (lnw < y0 + wh + BW);
  wire [15:0] lin_addr = (lnw - y0) * ww + (pxw - x0);

  assign win_active    = in_x && in_y;
  assign border_active = fr_x && fr_y && !win_active;
  assign border_color  = border_active ? col_a : 8'd0;
  assign rd_addr       = win_active ? lin_addr[AW-1:0] : '0;
  assign cap_we        = cap_valid && !frz_a;

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_active && border_active));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active && $past(win_active) && !$past(h_edge) && !$past(v_edge))
      |-> rd_addr == $past(rd_addr) + AW'(1));
  p_field_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (ln == '0) && (px == '0));
  p_line_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_edge && !v_edge && ln != LN_MAX) |=> (px == '0) && (ln == $past(ln) + 1'b1));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (hstep_a == $past(hstep_s)) && (frz_a == $past(frz_s)) && (col_a == $past(col_s)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !v_edge |=> $stable(hstep_a) && $stable(vstep_a) && $stable(size_a) && $stable(frz_a));
endmodule

// File: tb/tb_pip_window_ctrl.sv
module tb_pip_window_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 112;
  localparam int NV = 15;
  // hstep, vstep, size, line, pixel, exp_win, exp_border, exp_addr
  localparam int VEC [NV][8] = '{
    '{10, 5, 0,  5, 10, 1, 0,   0},
    '{10, 5, 0,  5, 33, 1, 0,  23},
    '{10, 5, 0,  5, 34, 0, 1,   0},
    '{10, 5, 0,  6, 12, 1, 0,  26},
    '{10, 5, 0, 22, 33, 1, 0, 431},
    '{10, 5, 0, 23, 20, 0, 1,   0},
    '{10, 5, 0, 25, 20, 0, 0,   0},
    '{10, 5, 0,  3,  8, 0, 1,   0},
    '{10, 5, 0,  4,  7, 0, 0,   0},
    '{20, 2, 1,  2, 20, 1, 0,   0},
    '{20, 2, 1, 25, 51, 1, 0, 767},
    '{20, 2, 1, 26, 52, 0, 1,   0},
    '{20, 2, 1,  2, 53, 0, 1,   0},
    '{63,40, 1, 40, 94, 1, 0,  31},
    '{ 0, 0, 0,  0,  2, 1, 0,   2}
  };

  logic clk = 0, rst_n = 0, hsync_in = 0, vsync_in = 0;
  logic reg_we = 0, cap_valid = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic win_active, border_active, cap_we;
  logic [7:0] border_color;
  logic [9:0] rd_addr;
  logic hact = 1, vact = 1;
  int nchk = 0, nfail = 0;

  pip_window_ctrl dut (.clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cap_valid(cap_valid),
    .win_active(win_active), .border_active(border_active), .border_color(border_color),
    .rd_addr(rd_addr), .cap_we(cap_we));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk); reg_we = 0;
  endtask

  // leaves the pixel count at 2
  task automatic hpulse(bit with_v, bit do_wr, int wa, int wd);
    @(negedge clk);
    hsync_in = hact;
    if (with_v) vsync_in = vact;
    if (do_wr) begin reg_we = 1; reg_addr = wa[1:0]; reg_wdata = wd[7:0]; end
    @(negedge clk); reg_we = 0;
    repeat (2) @(negedge clk);
    hsync_in = ~hact; vsync_in = ~vact;
  endtask

  task automatic to_line(int l);
    for (int i = 0; i < l; i++) begin
      repeat (LINE - 4) @(negedge clk);
      hpulse(0, 0, 0, 0);
    end
  endtask

  task automatic probe(int l, int x);
    hpulse(1, 0, 0, 0);
    to_line(l);
    repeat (x - 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    cap_valid = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset win", win_active, 0);
    chk("R1 reset border", border_active, 0);
    chk("R1 reset addr", rd_addr, 0);
    chk("R1 reset colour", border_color, 0);
    chk("R1 reset cap_we", cap_we, 1);

    for (int v = 0; v < NV; v++) begin
      wr(0, VEC[v][0]); wr(1, VEC[v][1]); wr(3, VEC[v][2]);
      probe(VEC[v][3], VEC[v][4]);
      chk($sformatf("R2 R3 R6 win vec%0d", v), win_active, VEC[v][5]);
      chk($sformatf("R5 border vec%0d", v), border_active, VEC[v][6]);
      chk($sformatf("R4 addr vec%0d", v), rd_addr, VEC[v][7]);
    end

    wr(0, 10); wr(1, 5); wr(3, 0); wr(2, 8'hA5);
    probe(3, 8);
    chk("R5 frame colour", border_color, 165);
    probe(7, 30);
    chk("R5 colour off in window", border_color, 0);

    probe(5, 10);
    chk("R9 before write win", win_active, 1);
    wr(0, 40);
    hpulse(0, 0, 0, 0);
    repeat (8) @(negedge clk);
    chk("R9 write deferred win", win_active, 1);
    chk("R9 write deferred addr", rd_addr, 24);
    probe(5, 10);
    chk("R9 applied next field", win_active, 0);
    wr(0, 10);
    probe(0, 2);

    hpulse(1, 1, 0, 30);
    to_line(5);
    repeat (8) @(negedge clk);
    chk("R9 coincident write old pos", win_active, 1);
    chk("R9 coincident write old addr", rd_addr, 0);
    probe(5, 10);
    chk("R9 coincident write later win", win_active, 0);
    chk("R9 coincident write later border", border_active, 0);
    wr(0, 10);

    wr(3, 2);
    @(negedge clk);
    chk("R8 R9 freeze deferred", cap_we, 1);
    probe(0, 2);
    chk("R8 freeze gates capture", cap_we, 0);
    cap_valid = 0;
    @(negedge clk);
    chk("R8 frozen idle", cap_we, 0);
    cap_valid = 1;
    wr(3, 0);
    probe(0, 2);
    chk("R8 unfreeze", cap_we, 1);

    wr(3, 12);
    hact = 0; vact = 0; hsync_in = 1; vsync_in = 1;
    repeat (3) @(negedge clk);
    probe(6, 12);
    chk("R7 active-low win", win_active, 1);
    chk("R7 active-low addr", rd_addr, 26);
    probe(3, 8);
    chk("R7 active-low border", border_active, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule